// File: doc/BRIEF.md
# USB Receive Endpoint Buffer with Polled Ownership Handover

This block is the packet buffer behind one host-to-device USB endpoint when the endpoint is serviced by polling. The USB side delivers one byte per strobe, followed by an end-of-packet strobe that carries a damaged flag. The block stores the bytes in a linear buffer. When the packet ends cleanly, or the buffer fills, the block passes the buffer to the CPU by raising a request bit. It also latches how many bytes are valid.

While the CPU holds the buffer, the block tells the USB side to answer NAK and ignores anything the USB side offers. The CPU reads the bytes one at a time through a read strobe, in the order they arrived. It then hands the buffer back with a clear strobe, which empties the buffer for the next packet.

Bad packets are handled according to the endpoint type:
- On a retrying endpoint (bulk, interrupt, control), a damaged packet is thrown away.
- On an isochronous endpoint, a damaged packet is still delivered, with a damage marker.
- On either type, a packet longer than the programmed maximum is thrown away.
- A maximum packet size larger than the buffer is a configuration error, and the endpoint refuses all data while it lasts.

Top module: `usb_rx_ep_buffer`

## Requirements
- R1: After reset, actReq, rxSize, cpuRdData, underrun and rxDamaged are all 0, and usbNak is 0 when cfgMaxPkt is at most DEPTH.
- R2: An end-of-packet strobe accepted while the USB side owns the buffer, for a packet that is not dropped, sets actReq on the next clock. In that same cycle rxSize takes the number of bytes accepted. A byte presented in the same cycle as the end-of-packet strobe counts as the packet's last byte, and a packet of zero length is valid.
- R3: When the DEPTH-th byte is written, actReq rises on the next clock with rxSize equal to DEPTH, without waiting for end of packet.
- R4: While actReq is 1, usbNak is 1 and every USB byte and end-of-packet strobe is ignored.
- R5: A cpuRead pulse while actReq is 1 and fewer than rxSize bytes have been read puts the next stored byte on cpuRdData one clock later. Bytes come out in arrival order, and cpuRdData holds its value between reads.
- R6: A cpuRead pulse while the USB side owns the buffer, or after all rxSize bytes have been read, gives cpuRdData = 0 one clock later and sets underrun. Underrun stays set until a cpuClear pulse; the buffer never wraps.
- R7: A cpuClear pulse while actReq is 1 drops actReq on the next clock and sets both the read position and the write position to zero. A cpuRead in the same cycle as a cpuClear is ignored.
- R8: With cfgIso = 0, a packet whose end-of-packet strobe carries usbBad = 1 is discarded. actReq stays 0, and the next packet holds only its own bytes.
- R9: With cfgIso = 1, a packet ending with usbBad = 1 is delivered like a good one and rxDamaged is 1. rxDamaged is 0 whenever actReq is 0.
- R10: On either endpoint type, a packet with more than cfgMaxPkt bytes is discarded whole and actReq stays 0.
- R11: When cfgMaxPkt is greater than DEPTH, cfgErr and usbNak are 1 and USB bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaxPkt | input | PKT_W | Programmed maximum packet size in bytes |
| cfgIso | input | 1 | 1 = isochronous endpoint (damaged packets delivered) |
| usbValid | input | 1 | USB-side byte strobe |
| usbData | input | DW | USB-side byte |
| usbEop | input | 1 | End-of-packet strobe |
| usbBad | input | 1 | Packet damaged, qualified by usbEop |
| usbNak | output | 1 | Tell the USB side to refuse data |
| cpuRead | input | 1 | Data-port read strobe |
| cpuClear | input | 1 | Clear the request bit and return the buffer |
| cpuRdData | output | DW | Data-port read result, registered |
| actReq | output | 1 | Request bit: 1 = CPU owns the buffer |
| rxSize | output | CNT_W | Latched count of valid bytes |
| underrun | output | 1 | Sticky bad-read flag |
| rxDamaged | output | 1 | Delivered isochronous packet was damaged |
| cfgErr | output | 1 | Maximum packet size exceeds DEPTH |

## Verification
Errors in the write position or the drop state appear at the ports only when the next packet is handed over. At that point rxSize is wrong, or the first byte read belongs to an earlier or discarded packet. The reference model therefore compares rxSize and every read byte on each packet.

Errors in ownership appear at once. In the cycle after a strobe, actReq or usbNak differs from the model. If the USB side is not refused, a byte written while the CPU owns the buffer shows up as a changed size on a later packet.

Errors in the read position appear as a wrong or early zero byte, together with underrun, on the very next read. The bench compares every output on every clock, so each of these errors is reported no later than the packet that exposes it.

// File: rtl/rxep_pkg.sv
package rxep_pkg;
  // Strobes from ownership control to the buffer datapath
  typedef struct packed {
    logic wrEn;    // store the incoming byte
    logic wrDrop;  // discard the packet in progress
    logic grant;   // latch size, buffer goes to CPU
    logic rdEn;    // fetch next stored byte
    logic rdZero;  // bad read, force zero
    logic ptrClr;  // CPU returns buffer
  } rxStrobe_t;
endpackage

// File: rtl/rxep_data.sv
module rxep_data
  import rxep_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        stb,
  input  logic [DW-1:0]    usbData,
  output logic [CNT_W-1:0] wrCnt,
  output logic [CNT_W-1:0] rdCnt,
  output logic [CNT_W-1:0] rxSize,
  output logic [DW-1:0]    rdData
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [CNT_W-1:0] cntAfter;

  assign cntAfter = wrCnt + CNT_W'(stb.wrEn);

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[wrCnt[AW-1:0]] <= usbData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt  <= '0;
      rdCnt  <= '0;
      rxSize <= '0;
      rdData <= '0;
    end else begin
      if (stb.ptrClr) begin
        wrCnt <= '0;
        rdCnt <= '0;
      end else begin
        if (stb.wrDrop)    wrCnt <= '0;
        else if (stb.wrEn) wrCnt <= cntAfter;
        if (stb.rdEn)      rdCnt <= rdCnt + CNT_W'(1);
      end
      if (stb.grant) rxSize <= cntAfter;
      if (stb.rdEn)        rdData <= mem[rdCnt[AW-1:0]];
      else if (stb.rdZero) rdData <= '0;
    end
  end

  AST_WR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    32'(wrCnt) <= DEPTH); // R3
  AST_RD_WITHIN_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt <= rxSize); // R5
endmodule

// File: rtl/rxep_ctrl.sv
module rxep_ctrl
  import rxep_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PKT_W = 11,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PKT_W-1:0] cfgMaxPkt,
  input  logic             cfgIso,
  input  logic             usbValid,
  input  logic             usbEop,
  input  logic             usbBad,
  input  logic             cpuRead,
  input  logic             cpuClear,
  input  logic [CNT_W-1:0] wrCnt,
  input  logic [CNT_W-1:0] rdCnt,
  input  logic [CNT_W-1:0] rxSize,
  output rxStrobe_t        stb,
  output logic             actReq,
  output logic             usbNak,
  output logic             underrun,
  output logic             rxDamaged,
  output logic             cfgErr
);
  logic tooLong;
  logic byteIn, eopIn, byteFits, overNow, fullNow, dropNow, grantNow, readOk;
  logic [CNT_W-1:0] cntAfter;

  assign cfgErr   = 32'(cfgMaxPkt) > DEPTH;
  assign usbNak   = actReq | cfgErr;
  assign byteIn   = ~usbNak & usbValid;
  assign eopIn    = ~usbNak & usbEop;
  assign byteFits = byteIn & ~tooLong & (32'(wrCnt) < 32'(cfgMaxPkt));
  assign overNow  = tooLong | (byteIn & ~byteFits);
  assign cntAfter = wrCnt + CNT_W'(byteFits);
  assign fullNow  = byteFits & (32'(cntAfter) == DEPTH);
  assign dropNow  = eopIn & (overNow | (usbBad & ~cfgIso));
  assign grantNow = eopIn ? ~dropNow : fullNow;
  assign readOk   = cpuRead & ~cpuClear & actReq & (rdCnt < rxSize);

  always_comb begin
    stb.wrEn   = byteFits;
    stb.wrDrop = dropNow;
    stb.grant  = grantNow;
    stb.rdEn   = readOk;
    stb.rdZero = cpuRead & ~cpuClear & ~readOk;
    stb.ptrClr = cpuClear & actReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actReq    <= 1'b0;
      tooLong   <= 1'b0;
      rxDamaged <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (stb.ptrClr) begin
        actReq    <= 1'b0;
        rxDamaged <= 1'b0;
      end else if (grantNow) begin
        actReq    <= 1'b1;
        rxDamaged <= eopIn & usbBad & cfgIso;
      end
      if (eopIn)                       tooLong <= 1'b0;
      else if (byteIn && !byteFits)    tooLong <= 1'b1;
      if (cpuClear)        underrun <= 1'b0;
      else if (stb.rdZero) underrun <= 1'b1;
    end
  end

  AST_GRANT_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(actReq) |-> rxSize == wrCnt); // R2
  AST_OWNED_HOLDS_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    actReq && !cpuClear |=> $stable(wrCnt)); // R4
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    underrun && !cpuClear |=> underrun); // R6
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    actReq && cpuClear |=> !actReq && wrCnt == '0 && rdCnt == '0); // R7
  AST_DROP_BAD: assert property (@(posedge clk) disable iff (!rstN)
    !usbNak && usbEop && usbBad && !cfgIso |=> !actReq && wrCnt == '0); // R8
  AST_IDLE_NO_DAMAGE: assert property (@(posedge clk) disable iff (!rstN)
    !actReq |-> !rxDamaged); // R9
  AST_CFG_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr && !actReq |=> $stable(wrCnt)); // R11
endmodule

// File: rtl/usb_rx_ep_buffer.sv
module usb_rx_ep_buffer
  import rxep_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned PKT_W = 11,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PKT_W-1:0] cfgMaxPkt,
  input  logic             cfgIso,
  input  logic             usbValid,
  input  logic [DW-1:0]    usbData,
  input  logic             usbEop,
  input  logic             usbBad,
  output logic             usbNak,
  input  logic             cpuRead,
  input  logic             cpuClear,
  output logic [DW-1:0]    cpuRdData,
  output logic             actReq,
  output logic [CNT_W-1:0] rxSize,
  output logic             underrun,
  output logic             rxDamaged,
  output logic             cfgErr
);
  rxStrobe_t        stb;
  logic [CNT_W-1:0] wrCnt, rdCnt;

  rxep_ctrl #(.DEPTH(DEPTH), .PKT_W(PKT_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMaxPkt(cfgMaxPkt), .cfgIso(cfgIso),
    .usbValid(usbValid), .usbEop(usbEop), .usbBad(usbBad),
    .cpuRead(cpuRead), .cpuClear(cpuClear),
    .wrCnt(wrCnt), .rdCnt(rdCnt), .rxSize(rxSize),
    .stb(stb), .actReq(actReq), .usbNak(usbNak), .underrun(underrun),
    .rxDamaged(rxDamaged), .cfgErr(cfgErr)
  );

  rxep_data #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .usbData(usbData),
    .wrCnt(wrCnt), .rdCnt(rdCnt), .rxSize(rxSize), .rdData(cpuRdData)
  );
endmodule

// File: tb/tb_usb_rx_ep_buffer.sv
`timescale 1ns/1ps
module tb_usb_rx_ep_buffer;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic [10:0] cfgMaxPkt = 11'd16;
  logic cfgIso = 1'b0, usbValid = 1'b0, usbEop = 1'b0, usbBad = 1'b0;
  logic [7:0] usbData = 8'h00;
  logic cpuRead = 1'b0, cpuClear = 1'b0;
  logic usbNak, actReq, underrun, rxDamaged, cfgErr;
  logic [7:0] cpuRdData;
  logic [CNT_W-1:0] rxSize;

  always #2 clk = ~clk;

  usb_rx_ep_buffer dut (
    .clk(clk), .rstN(rstN), .cfgMaxPkt(cfgMaxPkt), .cfgIso(cfgIso),
    .usbValid(usbValid), .usbData(usbData), .usbEop(usbEop), .usbBad(usbBad),
    .usbNak(usbNak), .cpuRead(cpuRead), .cpuClear(cpuClear),
    .cpuRdData(cpuRdData), .actReq(actReq), .rxSize(rxSize),
    .underrun(underrun), .rxDamaged(rxDamaged), .cfgErr(cfgErr)
  );

  int compared = 0, mismatched = 0, cyc = 0;

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] q[$];
  bit mOwned, mUnder, mDamaged, mTooLong;
  int mSize, mRdi;
  logic [7:0] mRd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete(); mOwned = 0; mUnder = 0; mDamaged = 0; mTooLong = 0;
      mSize = 0; mRdi = 0; mRd = 8'h00;
    end else begin
      bit oldOwned, refuse, justFull;
      oldOwned = mOwned;
      refuse = oldOwned || (int'(cfgMaxPkt) > DEPTH);
      justFull = 0;
      if (cpuClear) begin
        mUnder = 0;
        if (oldOwned) begin
          mOwned = 0; q.delete(); mRdi = 0; mDamaged = 0;
        end
      end else if (cpuRead) begin
        if (oldOwned && mRdi < mSize) begin
          mRd = q[mRdi]; mRdi++;
        end else begin
          mRd = 8'h00; mUnder = 1;
        end
      end
      if (!refuse) begin
        if (usbValid) begin
          if (!mTooLong && q.size() < int'(cfgMaxPkt)) begin
            q.push_back(usbData);
            justFull = (q.size() == DEPTH);
          end else mTooLong = 1;
        end
        if (usbEop) begin
          if (mTooLong || (usbBad && !cfgIso)) q.delete();
          else begin
            mOwned = 1; mSize = q.size(); mRdi = 0; mDamaged = usbBad && cfgIso;
          end
          mTooLong = 0;
        end else if (justFull) begin
          mOwned = 1; mSize = DEPTH; mRdi = 0; mDamaged = 0;
        end
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    check("R2", "actReq", int'(actReq), int'(mOwned));
    check("R3", "rxSize", int'(rxSize), mSize);
    check("R5", "cpuRdData", int'(cpuRdData), int'(mRd));
    check("R6", "underrun", int'(underrun), int'(mUnder));
    check("R9", "rxDamaged", int'(rxDamaged), int'(mDamaged));
    check("R4", "usbNak", int'(usbNak), int'(mOwned || int'(cfgMaxPkt) > DEPTH));
    check("R11", "cfgErr", int'(cfgErr), int'(int'(cfgMaxPkt) > DEPTH));
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic sendPkt(int n, logic [7:0] base, bit bad, bit eopOnLast);
    for (int i = 0; i < n; i++) begin
      usbValid = 1'b1; usbData = base + 8'(i);
      usbEop = eopOnLast && (i == n - 1);
      usbBad = bad && eopOnLast && (i == n - 1);
      tick();
    end
    usbValid = 1'b0;
    if (!eopOnLast || n == 0) begin
      usbEop = 1'b1; usbBad = bad; tick();
    end
    usbEop = 1'b0; usbBad = 1'b0;
  endtask

  task automatic readByte();
    cpuRead = 1'b1; tick(); cpuRead = 1'b0;
  endtask

  task automatic release_buf();
    cpuClear = 1'b1; tick(); cpuClear = 1'b0;
  endtask

  initial begin
    tick(); tick();
    rstN = 1'b1; tick();
    check("R1", "actReq reset", int'(actReq), 0);
    check("R1", "rxSize reset", int'(rxSize), 0);
    check("R1", "underrun reset", int'(underrun), 0);
    check("R1", "usbNak reset", int'(usbNak), 0);

    // R6: read while USB owns
    readByte();
    check("R6", "underrun on idle read", int'(underrun), 1);
    check("R6", "zero on idle read", int'(cpuRdData), 0);
    release_buf();
    check("R6", "underrun cleared", int'(underrun), 0);

    // R2: good packet, separate EOP
    sendPkt(5, 8'h10, 0, 0);
    check("R2", "actReq after eop", int'(actReq), 1);
    check("R2", "rxSize 5", int'(rxSize), 5);

    // R4: traffic while CPU owns
    check("R4", "nak while owned", int'(usbNak), 1);
    sendPkt(3, 8'hA0, 0, 0);
    check("R4", "size kept", int'(rxSize), 5);

    // R5: drain in order
    for (int i = 0; i < 5; i++) begin
      readByte();
      check("R5", "byte order", int'(cpuRdData), 16 + i);
    end
    readByte();
    check("R6", "no wrap after drain", int'(cpuRdData), 0);
    check("R6", "underrun after drain", int'(underrun), 1);

    // R7: clear with simultaneous read
    cpuClear = 1'b1; cpuRead = 1'b1; tick(); cpuClear = 1'b0; cpuRead = 1'b0;
    check("R7", "actReq released", int'(actReq), 0);
    sendPkt(3, 8'h30, 0, 1);
    check("R2", "eop with last byte size", int'(rxSize), 3);
    readByte();
    check("R7", "pointers reset first byte", int'(cpuRdData), 8'h30);
    release_buf();

    // R8: damaged packet on retrying endpoint
    sendPkt(4, 8'h50, 1, 0);
    check("R8", "bad dropped", int'(actReq), 0);
    sendPkt(2, 8'h60, 0, 0);
    check("R8", "next size own bytes", int'(rxSize), 2);
    readByte();
    check("R8", "next first byte", int'(cpuRdData), 8'h60);
    release_buf();

    // R3: fill without EOP
    sendPkt(DEPTH, 8'h40, 0, 0);
    check("R3", "full handover", int'(actReq), 1);
    check("R3", "full size", int'(rxSize), DEPTH);
    for (int i = 0; i < DEPTH; i++) readByte();
    check("R3", "last byte", int'(cpuRdData), 8'h4F);
    release_buf();

    // R10: overlong packet
    cfgMaxPkt = 11'd8; tick();
    sendPkt(9, 8'h70, 0, 0);
    check("R10", "overlong dropped", int'(actReq), 0);
    sendPkt(8, 8'h80, 0, 1);
    check("R10", "max size ok", int'(rxSize), 8);
    release_buf();

    // R9: isochronous damaged packet delivered
    cfgIso = 1'b1; tick();
    sendPkt(4, 8'h90, 1, 0);
    check("R9", "iso bad delivered", int'(actReq), 1);
    check("R9", "damage marker", int'(rxDamaged), 1);
    check("R9", "iso size", int'(rxSize), 4);
    release_buf();
    check("R9", "damage cleared", int'(rxDamaged), 0);
    sendPkt(10, 8'hB0, 0, 0);
    check("R10", "iso overlong dropped", int'(actReq), 0);
    cfgIso = 1'b0;

    // R11: configuration error
    cfgMaxPkt = 11'd17; tick();
    check("R11", "cfgErr", int'(cfgErr), 1);
    check("R11", "nak on cfgErr", int'(usbNak), 1);
    for (int i = 0; i < 3; i++) begin
      usbValid = 1'b1; usbData = 8'hC0; tick();
    end
    usbValid = 1'b0;
    cfgMaxPkt = 11'd8; tick();
    sendPkt(0, 8'h00, 0, 0);
    check("R11", "bytes ignored zero length", int'(rxSize), 0);
    check("R2", "zero length handover", int'(actReq), 1);
    readByte();
    check("R6", "read of empty packet", int'(underrun), 1);
    release_buf();
    tick(); tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule